// File: doc/BRIEF.md
# Supply Controller Serial Control Register

This block is the two-wire serial slave in front of a supply controller. It holds one 8-bit register. The top six bits are configuration that software writes: a current-limit style select, a transmit-path enable, a communication-mode select, cable-drop compensation, a high-voltage select and the main power enable. The bottom two bits are live diagnostic flags, over-temperature and overload, that other logic on the chip drives. The bus master writes the configuration with a single data byte. It can read back the whole byte at any time, and it may keep reading further copies by acknowledging each byte.

SCL and SDA are sampled on the system clock through a two-flop synchronizer. START and STOP are found from edges of the synchronized lines. SDA is driven open-drain through an output-enable: a 1 pulls the line low. The device address is fixed in its upper five bits, and a 2-bit strap supplies the two low bits. While the supply-good monitor reports undervoltage, the slave stays silent on the bus and holds the whole writable part of the register at zero. The register has no data stream, so every pin is a plain control or status signal with no valid/ready handshake. The system clock must run at least 8 times faster than SCL.

Top module: `pwr_ctl_i2c_regs`

## Requirements
- R1: After reset, `ctrl_o` is 0 and `sda_oe_o` is 0.
- R2: The address byte carries the 7-bit address, MSB first, in its bits 7..1. When this address equals {00010, strap_i}, the slave pulls SDA low during the ninth (acknowledge) clock. For any other address it never drives SDA until the next START.
- R3: In a write (address bit 0 = 0), the slave acknowledges the data byte. Data bits 7..2 appear on `ctrl_o[5:0]` 3 system clocks after the synchronizer input sees the SCL falling edge that ends the eighth data bit. At no other time does `ctrl_o` change, except as R7 describes.
- R4: In a read (address bit 0 = 1), the slave sends {ctrl_o[5:0], hot_flag_i, ovl_flag_i} MSB first. Bit 1 is the over-temperature flag and bit 0 is the overload flag, both taken as they stand when the byte is loaded.
- R5: After a read byte, a master ACK (SDA low in the ninth clock) makes the slave send the register again. A NACK makes it release SDA and stay silent until the next START.
- R6: Data bits 1..0 of a write are ignored. A later read returns the live flags in those positions.
- R7: While `uv_i` is 1, `ctrl_o` is forced to 0 from the next clock on. The slave acknowledges nothing and never drives SDA. After `uv_i` falls, `ctrl_o` stays 0 until it is written again.
- R8: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP in the middle of a byte ends the transaction and the register does not change. The slave changes SDA only after it sees SCL fall.
- R9: Further data bytes in the same write transaction are each acknowledged, and each one overwrites the register.
- R10: The strap input selects the two low address bits, which gives one of the addresses 0001000 through 0001011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 2 | Low two address bits from the strap |
| uv_i | input | 1 | Undervoltage lockout, active high |
| hot_flag_i | input | 1 | Over-temperature flag, returned in bit 1 |
| ovl_flag_i | input | 1 | Overload flag, returned in bit 0 |
| ctrl_o | output | 6 | Configuration bits 5..0 (register bits 7..2) |

## Verification
Every response of the block is due a fixed number of clocks after a line change. The slave's action on an SCL falling edge, whether a register write or a change in SDA drive, lands on the third rising clock after the edge reaches the pad input. A change on `uv_i` clears the register on the very next rising clock. The bench keeps a behavioural model of `ctrl_o` that schedules each expected update at exactly that cycle and compares it with the output one nanosecond after every falling clock edge. During phases where the slave must be silent, the same comparison also checks that `sda_oe_o` stays 0. Acknowledge bits and read data are sampled half-way through SCL high, which is long after the slave has settled.

// File: rtl/pwrctl_i2c_pkg.sv
package pwrctl_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_ACK_R
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  // per line: STAGES synchronizer flops plus one history flop
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw_i[g]};
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_lvl_i,
  input  logic scl_rise_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // SCL must be high and steady while SDA moves
  logic scl_steady_hi;
  assign scl_steady_hi = scl_lvl_i & ~scl_rise_i;
  assign start_o = scl_steady_hi & sda_fall_i;
  assign stop_o  = scl_steady_hi & sda_rise_i;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import pwrctl_i2c_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_lvl_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             hold_i,
  input  logic [REG_W-2:0] dev_addr_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             wr_stb_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             sda_oe_o
);
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(REG_W);

  bus_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] rx_sh;
  logic [REG_W-1:0] tx_sh;
  logic             rnw;
  logic             m_ack;
  logic             abort;

  assign abort     = hold_i | stop_i | start_i;
  assign wr_stb_o  = (state == ST_WR) && scl_fall_i && (cnt == FULL) && !abort;
  assign wr_data_o = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rnw      <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (hold_i || stop_i) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise_i) begin
            rx_sh <= {rx_sh[REG_W-2:0], sda_lvl_i};
            cnt   <= cnt + CNT_W'(1);
          end else if (scl_fall_i && cnt == FULL) begin
            if (rx_sh[REG_W-1:1] == dev_addr_i) begin
              sda_oe_o <= 1'b1;
              rnw      <= rx_sh[0];
              state    <= ST_ACK_A;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall_i) begin
            if (rnw) begin
              tx_sh    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[REG_W-1];
              cnt      <= CNT_W'(1);
              state    <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              state    <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            rx_sh <= {rx_sh[REG_W-2:0], sda_lvl_i};
            cnt   <= cnt + CNT_W'(1);
          end else if (scl_fall_i && cnt == FULL) begin
            sda_oe_o <= 1'b1;
            state    <= ST_ACK_W;
          end
        end
        ST_ACK_W: begin
          if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt      <= '0;
            state    <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (cnt == FULL) begin
              sda_oe_o <= 1'b0;
              state    <= ST_ACK_R;
            end else begin
              sda_oe_o <= ~tx_sh[REG_W-2];
              tx_sh    <= {tx_sh[REG_W-2:0], 1'b0};
              cnt      <= cnt + CNT_W'(1);
            end
          end
        end
        ST_ACK_R: begin
          if (scl_rise_i) begin
            m_ack <= ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (m_ack) begin
              tx_sh    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[REG_W-1];
              cnt      <= CNT_W'(1);
              state    <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe_o <= 1'b0;
        end
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe_o); // R5
  AST_DRIVE_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_o != $past(sda_oe_o)) && !$past(abort)) |-> $past(scl_fall_i)); // R8
endmodule

// File: rtl/ctrl_status_reg.sv
module ctrl_status_reg #(
  parameter int REG_W = 8,
  parameter int RO_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  wr_stb_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic [RO_W-1:0]       flags_i,
  output logic [REG_W-RO_W-1:0] ctrl_o,
  output logic [REG_W-1:0]      rd_data_o
);
  localparam int CTRL_W = REG_W - RO_W;

  logic [CTRL_W-1:0] ctrl_q;

  // only the upper bits are stored; the flag positions of a write are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (clr_i)    ctrl_q <= '0;
    else if (wr_stb_i) ctrl_q <= wr_data_i[REG_W-1:RO_W];
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = {ctrl_q, flags_i};

  AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ctrl_q == '0)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_stb_i) |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/pwr_ctl_i2c_regs.sv
module pwr_ctl_i2c_regs #(
  parameter int REG_W   = 8,
  parameter int RO_W    = 2,
  parameter int STRAP_W = 2,
  parameter int STAGES  = 2,
  parameter logic [REG_W-2-STRAP_W:0] ADDR_HI = 'b00010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  uv_i,
  input  logic                  hot_flag_i,
  input  logic                  ovl_flag_i,
  output logic [REG_W-RO_W-1:0] ctrl_o
);
  localparam int ADDR_W = REG_W - 1;

  logic [1:0]        lvl, rise, fall;
  logic              start, stop;
  logic [ADDR_W-1:0] dev_addr;
  logic [REG_W-1:0]  rd_data;
  logic [REG_W-1:0]  wr_data;
  logic              wr_stb;

  assign dev_addr = {ADDR_HI, strap_i};

  // line 1 = SCL, line 0 = SDA
  i2c_line_sync #(.LINES(2), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_cond_detect u_cond (
    .scl_lvl_i  (lvl[1]),
    .scl_rise_i (rise[1]),
    .sda_rise_i (rise[0]),
    .sda_fall_i (fall[0]),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_byte_fsm #(.REG_W(REG_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (rise[1]),
    .scl_fall_i (fall[1]),
    .sda_lvl_i  (lvl[0]),
    .start_i    (start),
    .stop_i     (stop),
    .hold_i     (uv_i),
    .dev_addr_i (dev_addr),
    .rd_data_i  (rd_data),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  ctrl_status_reg #(.REG_W(REG_W), .RO_W(RO_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (uv_i),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data),
    .flags_i   ({hot_flag_i, ovl_flag_i}),
    .ctrl_o    (ctrl_o),
    .rd_data_o (rd_data)
  );

  AST_UV_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !sda_oe_o); // R7
  AST_UV_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (ctrl_o == '0)); // R7
endmodule

// File: tb/pwr_ctl_i2c_regs_tb_top.sv
`timescale 1ns/1ps
module pwr_ctl_i2c_regs_tb_top;
  localparam int HP = 10; // SCL half period in system clocks

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_bus;
  logic [1:0] strap = 2'd0;
  logic       uv = 1'b0, hot = 1'b0, ovl = 1'b0;
  logic [5:0] ctrl;

  assign sda_bus = sda_m & ~sda_oe;

  pwr_ctl_i2c_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .uv_i(uv), .hot_flag_i(hot), .ovl_flag_i(ovl), .ctrl_o(ctrl)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic done = 1'b0;
  // behavioural model of ctrl_o and of bus silence
  logic       model_on = 1'b0, quiet = 1'b0;
  logic [5:0] exp_ctrl = '0;
  logic       pend_v = 1'b0;
  logic [5:0] pend_val = '0;
  int         pend_due = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(negedge clk);
    #1;
    if (model_on) begin
      if (pend_v && cyc >= pend_due) begin
        exp_ctrl = pend_val;
        pend_v   = 1'b0;
      end
      checks++;
      if (ctrl !== exp_ctrl) begin
        errors++;
        $display("FAIL R3 per-cycle ctrl_o cyc=%0d actual=%b expected=%b", cyc, ctrl, exp_ctrl);
      end
      if (quiet) begin
        checks++;
        if (sda_oe !== 1'b0) begin
          errors++;
          $display("FAIL R7 silent phase sda_oe actual=%b expected=0 cyc=%0d", sda_oe, cyc);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic schedule(input logic [5:0] v, input int dly);
    pend_val = v;
    pend_due = cyc + dly;
    pend_v   = 1'b1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b0; wt(HP);
  endtask

  task automatic bus_stop();
    wt(HP/2); sda_m = 1'b0; wt(HP/2);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
  endtask

  task automatic send_bit(input logic b);
    wt(HP/2); sda_m = b; wt(HP/2);
    scl_m = 1'b1; wt(HP);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(HP/2); sda_m = 1'b1; wt(HP/2);
    scl_m = 1'b1; wt(HP/2);
    b = sda_bus; wt(HP/2);
    scl_m = 1'b0;
  endtask

  // sends a byte; if apply, bits 7..2 are due on ctrl_o 3 clocks after the last fall
  task automatic send_byte(input logic [7:0] d, input logic apply, output logic ackbit);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    if (apply) schedule(d[7:2], 3);
    recv_bit(ackbit);
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~master_ack);
  endtask

  logic       a;
  logic [7:0] rb;

  initial begin
    wt(5);
    chk("R1 reset ctrl_o", ctrl, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    wt(5);

    // write at strap 0: address 0001000 -> byte 0x10
    bus_start();
    send_byte(8'h10, 1'b0, a); chk("R2 address ack", a, 0);
    send_byte(8'hAF, 1'b1, a); chk("R3 data ack", a, 0);
    bus_stop();
    chk("R3 ctrl after write", ctrl, 6'b101011);

    // read: flags hot=1 ovl=0, low bits of previous write (11) ignored
    hot = 1'b1; ovl = 1'b0;
    bus_start();
    send_byte(8'h11, 1'b0, a); chk("R4 read address ack", a, 0);
    read_byte(1'b0, rb);
    chk("R4 R6 read byte with flags", rb, 8'hAE);
    wt(6);
    chk("R5 released after NACK", sda_oe, 0);
    bus_stop();

    // read twice with master ACK then NACK
    hot = 1'b0; ovl = 1'b1;
    bus_start();
    send_byte(8'h11, 1'b0, a); chk("R5 address ack", a, 0);
    read_byte(1'b1, rb); chk("R5 first byte", rb, 8'hAD);
    read_byte(1'b0, rb); chk("R5 repeat byte after ACK", rb, 8'hAD);
    wt(6);
    chk("R5 silent after NACK", sda_oe, 0);
    bus_stop();

    // wrong address at strap 0: 0001001
    quiet = 1'b1;
    bus_start();
    send_byte(8'h12, 1'b0, a); chk("R2 R10 foreign address no ack", a, 1);
    send_byte(8'hFC, 1'b0, a); chk("R2 foreign data no ack", a, 1);
    bus_stop();
    quiet = 1'b0;
    chk("R2 ctrl untouched by foreign write", ctrl, 6'b101011);

    // strap 1 accepts 0001001
    strap = 2'd1; wt(3);
    bus_start();
    send_byte(8'h12, 1'b0, a); chk("R10 strap1 ack", a, 0);
    send_byte(8'h24, 1'b1, a); chk("R10 strap1 data ack", a, 0);
    bus_stop();
    chk("R10 strap1 write", ctrl, 6'b001001);

    // strap 2, then two data bytes in one write
    strap = 2'd2; wt(3);
    bus_start();
    send_byte(8'h14, 1'b0, a); chk("R10 strap2 ack", a, 0);
    send_byte(8'h54, 1'b1, a); chk("R3 strap2 data ack", a, 0);
    bus_stop();
    chk("R10 strap2 write", ctrl, 6'b010101);
    bus_start();
    send_byte(8'h14, 1'b0, a);
    send_byte(8'hFF, 1'b1, a); chk("R9 first byte ack", a, 0);
    chk("R9 first byte applied", ctrl, 6'b111111);
    send_byte(8'h03, 1'b1, a); chk("R9 extra byte ack", a, 0);
    bus_stop();
    chk("R9 extra byte overwrote", ctrl, 6'b000000);

    // STOP after four data bits aborts
    bus_start();
    send_byte(8'h14, 1'b0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R8 mid-byte STOP no write", ctrl, 6'b000000);
    bus_start();
    send_byte(8'h14, 1'b0, a); chk("R8 next transaction ack", a, 0);
    send_byte(8'h8C, 1'b1, a);
    bus_stop();
    chk("R8 write after abort", ctrl, 6'b100011);

    // undervoltage
    uv = 1'b1; schedule(6'b0, 1);
    wt(3);
    chk("R7 cleared under lockout", ctrl, 0);
    quiet = 1'b1;
    bus_start();
    send_byte(8'h14, 1'b0, a); chk("R7 no ack under lockout", a, 1);
    send_byte(8'hFC, 1'b0, a); chk("R7 no data ack under lockout", a, 1);
    bus_stop();
    uv = 1'b0; wt(5);
    quiet = 1'b0;
    chk("R7 stays zero after release", ctrl, 0);

    // normal again, read all ones
    hot = 1'b1; ovl = 1'b1;
    bus_start();
    send_byte(8'h14, 1'b0, a); chk("R7 ack after release", a, 0);
    send_byte(8'hFC, 1'b1, a);
    bus_stop();
    bus_start();
    send_byte(8'h15, 1'b0, a);
    read_byte(1'b0, rb); chk("R4 full read", rb, 8'hFF);
    bus_stop();
    wt(10);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule